// File: doc/BRIEF.md
# Cellular Array Phase Sequencer

This block drives a one-dimensional cellular automaton array through a repeating cycle of three phases. After reset it fills the array column by column from an input word stream. It then lets every cell evolve for a programmable number of generations. Next it reads the array back out column by column towards an output FIFO. After that it returns to evolution. It never loads again until the next reset.

A single one-hot token serves as the column cursor in both the load phase and the save phase. The sequencer drives three per-column enable vectors: a load select, a save select and an evolve strobe. It also drives two summary strobes, plus a FIFO push that is delayed by a fixed number of stages so that it lines up with a registered data path.

When the output FIFO reports full, the whole sequence freezes in place and no strobe is asserted. Every register keeps its value. The sequence resumes on the first cycle with space available.

Top module: `ca_phase_sequencer`

## Requirements
- R1: While reset is held and input-valid is low, enR, enW, work, enL, enS and fifoPush are all zero. The first accepted word after reset selects column 0.
- R2: In the load phase, each accepted word asserts exactly one bit of enR. The bits run from column 0 upward, one column per accepted word. enL is high exactly when a word is accepted.
- R3: A load-phase cycle with inValid low asserts no enR bit and does not move the cursor.
- R4: After the word for column NUM_COLS-1 is accepted, work is asserted on every column. It stays asserted for genCount unfrozen cycles in a row, where genCount is the value present on the cycle that ended the previous phase.
- R5: A genCount of 0 gives exactly one work cycle.
- R6: After the work cycles, the save phase asserts one bit of enW per unfrozen cycle, from column 0 up to column NUM_COLS-1. enS is high on each of those cycles.
- R7: After the save cycle for column NUM_COLS-1, the sequencer goes straight back to the work phase and never re-enters the load phase.
- R8: While outFull is high, every output strobe is low and no state advances. The sequence continues from the same point once outFull falls.
- R9: fifoPush equals enS delayed by OUT_LAT unfrozen clock edges, and it is low while outFull is high.
- R10: A change of genCount during a work phase does not change the length of that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| genCount | input | GEN_W | Generations per work phase (0 counts as 1) |
| inValid | input | 1 | An input word is present |
| outFull | input | 1 | Output FIFO cannot accept a word; freezes the sequence |
| enR | output | NUM_COLS | Per-column load select |
| enW | output | NUM_COLS | Per-column save select |
| work | output | NUM_COLS | Per-column evolve strobe |
| enL | output | 1 | An input word is consumed this cycle |
| enS | output | 1 | A column is being saved this cycle |
| fifoPush | output | 1 | Delayed push strobe for the output FIFO |

## Verification
A cycle-level model in the bench tracks the expected phase, cursor, remaining generations and push pipeline. The design runs through four reset episodes:
- Valid input with no backpressure isolates the basic phase ordering and the generation counts 0 to 15.
- Valid input every third cycle shows whether the cursor waits for accepted words.
- Pseudo-random valid and full patterns expose any state that moves while frozen.
- Long full bursts check that the delayed push holds and later releases the exact saved sequence.

Because genCount changes independently of the phase boundaries, the episodes also show whether the count is sampled only at phase entry.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_WORK = 2'd1,
    PH_SAVE = 2'd2
  } phase_e;

  // strobes from the control to the column datapath
  typedef struct packed {
    logic load;     // a word is accepted at the cursor column
    logic work;     // all columns evolve this cycle
    logic save;     // the cursor column is read out this cycle
    logic advance;  // rotate the column token
  } seqStrb_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int GEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [GEN_W-1:0] genCount,
  input  logic             inValid,
  input  logic             outFull,
  input  logic             tokLast,
  output seqStrb_t         strb
);

  phase_e           phase;
  logic [GEN_W-1:0] genLeft;
  logic [GEN_W-1:0] genLoad;

  // remaining extra generations after the current one; 0 means one cycle
  assign genLoad = (genCount == '0) ? '0 : genCount - GEN_W'(1);

  always_comb begin
    strb.load    = (phase == PH_LOAD) && inValid && !outFull;
    strb.work    = (phase == PH_WORK) && !outFull;
    strb.save    = (phase == PH_SAVE) && !outFull;
    strb.advance = strb.load || strb.save;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_LOAD;
      genLeft <= '0;
    end else begin
      unique case (phase)
        PH_LOAD: if (strb.load && tokLast) begin
          phase   <= PH_WORK;
          genLeft <= genLoad;
        end
        PH_WORK: if (strb.work) begin
          if (genLeft == '0) phase <= PH_SAVE;
          else               genLeft <= genLeft - GEN_W'(1);
        end
        PH_SAVE: if (strb.save && tokLast) begin
          phase   <= PH_WORK;
          genLeft <= genLoad;
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end

  // R8: a full output side holds phase and counter
  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    outFull |=> ($stable(phase) && $stable(genLeft)));

  // R4: each unfrozen work cycle with generations left counts down once
  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WORK && !outFull && genLeft != '0)
      |=> (phase == PH_WORK && genLeft == $past(genLeft) - GEN_W'(1)));

  // R7: the last save column hands straight back to work
  assert_save_returns_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SAVE && tokLast && !outFull) |=> (phase == PH_WORK));

  // R7: loading happens once per reset
  assert_no_reload_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_LOAD) |=> (phase != PH_LOAD));

endmodule

// File: rtl/seq_colpath.sv
module seq_colpath
  import seq_pkg::*;
#(
  parameter int NUM_COLS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrb_t            strb,
  input  logic                outFull,
  output logic                tokLast,
  output logic [NUM_COLS-1:0] enR,
  output logic [NUM_COLS-1:0] enW,
  output logic [NUM_COLS-1:0] work,
  output logic                enL,
  output logic                enS
);

  logic [NUM_COLS-1:0] token;

  // rotating cursor; wrapping from the last column restarts at column 0
  always_ff @(posedge clk) begin
    if (!rstN)             token <= NUM_COLS'(1);
    else if (strb.advance) token <= {token[NUM_COLS-2:0], token[NUM_COLS-1]};
  end

  assign tokLast = token[NUM_COLS-1];

  for (genvar c = 0; c < NUM_COLS; c++) begin : gCol
    assign enR[c]  = token[c] & strb.load;
    assign enW[c]  = token[c] & strb.save;
    assign work[c] = strb.work;
  end

  assign enL = |enR;
  assign enS = |enW;

  // R2: the cursor is always a single column
  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(token) == 1);

  // R6: load, evolve and save never overlap
  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({enL, enS, work[0]}) <= 1);

  // R8: nothing is strobed while the output side is full
  assert_full_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    outFull |-> (enR == '0 && enW == '0 && work == '0));

  // R3: the cursor moves only on an accepted word or a save step
  assert_cursor_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!enL && !enS) |=> $stable(token));

endmodule

// File: rtl/seq_pushdelay.sv
module seq_pushdelay #(
  parameter int OUT_LAT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic hold,
  input  logic inStrobe,
  output logic outStrobe
);

  if (OUT_LAT == 0) begin : gDirect
    assign outStrobe = inStrobe & ~hold;
  end else begin : gPipe
    logic [OUT_LAT-1:0] stage;
    for (genvar s = 0; s < OUT_LAT; s++) begin : gStage
      always_ff @(posedge clk) begin
        if (!rstN)     stage[s] <= 1'b0;
        else if (!hold) stage[s] <= (s == 0) ? inStrobe : stage[(s == 0) ? 0 : s - 1];
      end
    end
    assign outStrobe = stage[OUT_LAT-1] & ~hold;
  end

  // R9: no push reaches a full FIFO
  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    hold |-> !outStrobe);

endmodule

// File: rtl/ca_phase_sequencer.sv
module ca_phase_sequencer
  import seq_pkg::*;
#(
  parameter int NUM_COLS = 32,
  parameter int GEN_W    = 16,
  parameter int OUT_LAT  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [GEN_W-1:0]    genCount,
  input  logic                inValid,
  input  logic                outFull,
  output logic [NUM_COLS-1:0] enR,
  output logic [NUM_COLS-1:0] enW,
  output logic [NUM_COLS-1:0] work,
  output logic                enL,
  output logic                enS,
  output logic                fifoPush
);

  seqStrb_t strb;
  logic     tokLast;

  seq_ctrl #(.GEN_W(GEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .genCount(genCount), .inValid(inValid),
    .outFull(outFull), .tokLast(tokLast), .strb(strb)
  );

  seq_colpath #(.NUM_COLS(NUM_COLS)) uCols (
    .clk(clk), .rstN(rstN), .strb(strb), .outFull(outFull),
    .tokLast(tokLast), .enR(enR), .enW(enW), .work(work),
    .enL(enL), .enS(enS)
  );

  seq_pushdelay #(.OUT_LAT(OUT_LAT)) uPush (
    .clk(clk), .rstN(rstN), .hold(outFull), .inStrobe(enS),
    .outStrobe(fifoPush)
  );

endmodule

// File: tb/sim_ca_phase_sequencer.sv
`timescale 1ns/100ps
module sim_ca_phase_sequencer;

  localparam int C   = 4;
  localparam int GW  = 4;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN;
  logic [GW-1:0] genCount;
  logic          inValid, outFull;
  logic [C-1:0]  enR, enW, work;
  logic          enL, enS, fifoPush;

  ca_phase_sequencer #(.NUM_COLS(C), .GEN_W(GW), .OUT_LAT(LAT)) u0 (
    .clk(clk), .rstN(rstN), .genCount(genCount), .inValid(inValid),
    .outFull(outFull), .enR(enR), .enW(enW), .work(work),
    .enL(enL), .enS(enS), .fifoPush(fifoPush)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference state: 0 load, 1 work, 2 save
  int mPhase, mCol, mLeft;
  bit mZero, mFromSave;
  bit [LAT-1:0] mPipe;
  logic [15:0] lfsr;

  initial begin
    rstN = 1'b0; inValid = 1'b0; outFull = 1'b0; genCount = '0;
    lfsr = 16'hACE1;
    for (int ep = 0; ep < 4; ep++) begin
      rstN = 1'b0; inValid = 1'b0; outFull = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "enR reset", 32'(enR), 0);
      chk("R1", "enW reset", 32'(enW), 0);
      chk("R1", "work reset", 32'(work), 0);
      chk("R1", "enL/enS reset", {30'd0, enL, enS}, 0);
      chk("R1", "fifoPush reset", 32'(fifoPush), 0);
      @(negedge clk);
      rstN = 1'b1;
      mPhase = 0; mCol = 0; mLeft = 0; mZero = 0; mFromSave = 0; mPipe = '0;
      for (int cyc = 0; cyc < 700; cyc++) begin
        bit acc;
        logic [C-1:0] expR, expW, expWk;
        bit expPush;
        string lt, wt, st;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ep)
          0: begin inValid = 1'b1; outFull = 1'b0; end
          1: begin inValid = (cyc % 3 == 0); outFull = 1'b0; end
          2: begin inValid = lfsr[0] | lfsr[3]; outFull = lfsr[5] & lfsr[2]; end
          default: begin inValid = lfsr[1] | lfsr[4]; outFull = ((cyc / 11) % 4 == 3); end
        endcase
        genCount = GW'((cyc / 9 + ep * 5) % 16);
        #1;
        acc     = (mPhase == 0) && inValid && !outFull;
        expR    = acc ? C'(1 << mCol) : '0;
        expWk   = (mPhase == 1 && !outFull) ? '1 : '0;
        expW    = (mPhase == 2 && !outFull) ? C'(1 << mCol) : '0;
        expPush = mPipe[LAT-1] & !outFull;
        lt = outFull ? "R8" : (!inValid ? "R3" : (mCol == 0 ? "R1 R2" : "R2"));
        wt = outFull ? "R8" : (mZero ? "R5" : (mFromSave ? "R7 R10" : "R4 R10"));
        st = outFull ? "R8" : "R6";
        chk(lt, "enR", 32'(enR), 32'(expR));
        chk(lt, "enL", 32'(enL), 32'(|expR));
        chk(wt, "work", 32'(work), 32'(expWk));
        chk(st, "enW", 32'(enW), 32'(expW));
        chk(st, "enS", 32'(enS), 32'(|expW));
        chk("R9", "fifoPush", 32'(fifoPush), 32'(expPush));
        // advance reference at the coming edge
        if (!outFull) begin
          mPipe = {mPipe[LAT-2:0], |expW};
          case (mPhase)
            0: if (acc) begin
              if (mCol == C - 1) begin
                mPhase = 1; mCol = 0; mFromSave = 0;
                mZero = (genCount == 0);
                mLeft = (genCount == 0) ? 1 : int'(genCount);
              end else mCol++;
            end
            1: begin
              mLeft--;
              if (mLeft == 0) begin mPhase = 2; mCol = 0; end
            end
            default: begin
              if (mCol == C - 1) begin
                mPhase = 1; mCol = 0; mFromSave = 1;
                mZero = (genCount == 0);
                mLeft = (genCount == 0) ? 1 : int'(genCount);
              end else mCol++;
            end
          endcase
        end
        @(negedge clk);
      end
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule